// File: doc/BRIEF.md
# Posted Write Redelivery Controller

This block drives the repeated delivery of one buffered posted write on the target bus. The initiator has already finished its side of the write, so a termination from the target cannot be passed back to it. The controller keeps the delivery going until the data is accepted, the target aborts, or an attempt budget runs out. Entries arrive over a valid/ready handshake carrying a start address, a bus command, a byte-enable nibble and a DWORD count. Each delivery attempt leaves through a second valid/ready handshake. The bus engine reports the outcome of each attempt on a one-cycle termination strobe, together with the number of DWORDs the target accepted.

After every termination the controller works out what comes next:
- a fresh attempt at the same address;
- an attempt that resumes at the first DWORD not yet accepted, with the command downgraded if needed;
- completion;
- a flush, with status bits set and possibly a system-error request.

The termination codes are: 0 = normal, 1 = retry, 2 = disconnect, 3 = abort. Command 4'hF is memory-write-and-invalidate and 4'h7 is plain memory write.

Back-pressure rules:
- `ent_ready` is high only while no entry is active. An entry is taken on a clock edge where both `ent_valid` and `ent_ready` are high.
- `att_valid` stays high, with stable fields, until `att_ready` is sampled high.
- Exactly one termination is consumed per accepted attempt. A termination strobe that arrives while no attempt is outstanding is ignored.

Top module: `pwr_redeliver_ctrl`

## Requirements
- R1: An entry is accepted only while `ent_ready` is high, which is only when idle. The first attempt carries the entry's address, command, byte enables and DWORD count unchanged.
- R2: Only one attempt is outstanding at a time. After an attempt is accepted, `att_valid` stays low until its termination has been consumed.
- R3: A normal termination (code 0) retires the entry. The cycle after the strobe, `done_pulse` is 1 and `done_flushed` is 0.
- R4: A retry termination (code 1) issues a new attempt with exactly the same address, command, byte enables and count.
- R5: A disconnect (code 2) with `term_dw` below the remaining count issues a new attempt. Its address is the old address plus 4 × `term_dw`, its count is reduced by `term_dw`, and its byte enables are unchanged.
- R6: If such a disconnect has `term_dw` > 0 and the command is 4'hF, later attempts use 4'h7. If `term_dw` is 0, or the command is anything else, the command is kept.
- R7: A disconnect with `term_dw` at or above the remaining count retires the entry like a normal completion.
- R8: An abort (code 3) sets the sticky `sts_rx_tabort` and flushes the entry: `done_pulse` and `done_flushed` are both 1. If `cfg_serr_en` is set, `serr_req` pulses and the sticky `sts_sig_serr` is set.
- R9: If the MAX_ATT-th attempt of an entry ends in retry, or in a disconnect that leaves data behind, the entry is flushed. `serr_req` pulses, and `sts_sig_serr` is set, only when `cfg_serr_en` is 1 and `cfg_nodeliv_dis` is 0.
- R10: The attempt count restarts for each new entry, so every entry gets the full MAX_ATT attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_serr_en | input | 1 | System-error reporting enable |
| cfg_nodeliv_dis | input | 1 | Suppresses system error on delivery failure |
| ent_valid | input | 1 | New posted write entry valid |
| ent_ready | output | 1 | Controller idle, can take an entry |
| ent_addr | input | AW | Entry start byte address (DWORD aligned) |
| ent_cmd | input | 4 | Entry bus command |
| ent_be | input | 4 | Byte enables of the first DWORD |
| ent_len | input | LW | Entry DWORD count (at least 1) |
| att_valid | output | 1 | Attempt start request |
| att_ready | input | 1 | Bus engine takes the attempt |
| att_addr | output | AW | Attempt address |
| att_cmd | output | 4 | Attempt bus command |
| att_be | output | 4 | Attempt first byte enables |
| att_len | output | LW | DWORDs still to deliver |
| term_valid | input | 1 | Termination report strobe |
| term_code | input | 2 | 0 normal, 1 retry, 2 disconnect, 3 abort |
| term_dw | input | LW | DWORDs accepted in the attempt |
| done_pulse | output | 1 | Entry retired (one cycle) |
| done_flushed | output | 1 | With done_pulse: data was dropped |
| serr_req | output | 1 | System-error request pulse |
| sts_rx_tabort | output | 1 | Sticky: target abort received |
| sts_sig_serr | output | 1 | Sticky: system error signalled |

## Verification
The bench builds the block with AW=16, LW=4 and MAX_ATT=4. The small attempt budget lets every retry chain run all the way to the failure decision within a few cycles. The bench walks every entry length from 1 to 7 against every disconnect count from 0 up to the length, for both write commands, so every partial-delivery split and every full-delivery boundary is covered. It then exhausts all four combinations of the two enables, running back-to-back entries through the attempt limit, and drives aborts with system-error reporting disabled and enabled.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    TERM_NORMAL = 2'd0,
    TERM_RETRY  = 2'd1,
    TERM_DISC   = 2'd2,
    TERM_ABORT  = 2'd3
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } pwr_state_e;

  localparam logic [3:0] CMD_MW  = 4'h7;
  localparam logic [3:0] CMD_MWI = 4'hF;
endpackage

// File: rtl/pwr_attempt_ctr.sv
module pwr_attempt_ctr #(
  parameter int MAX_ATT = 1 << 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_ATT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (inc)        cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(MAX_ATT));

  // R9: the budget is never exceeded
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_ATT));
  // R10: a clear always brings the count back to zero
  p_cnt_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !at_limit);
endmodule

// File: rtl/pwr_next_calc.sv
module pwr_next_calc
  import pwr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [3:0]    cur_cmd,
  input  logic [LW-1:0] cur_rem,
  input  logic [1:0]    code,
  input  logic [LW-1:0] dw,
  output logic [AW-1:0] nxt_addr,
  output logic [3:0]    nxt_cmd,
  output logic [LW-1:0] nxt_rem,
  output logic          finished,
  output logic          aborted,
  output logic          leftover
);
  always_comb begin
    nxt_addr = cur_addr;
    nxt_cmd  = cur_cmd;
    nxt_rem  = cur_rem;
    finished = 1'b0;
    aborted  = 1'b0;
    leftover = 1'b0;
    case (term_e'(code))
      TERM_NORMAL: finished = 1'b1;
      TERM_RETRY:  leftover = 1'b1;
      TERM_DISC: begin
        if (dw >= cur_rem) begin
          finished = 1'b1;
        end else begin
          leftover = 1'b1;
          nxt_addr = cur_addr + (AW'(dw) << 2);
          nxt_rem  = cur_rem - dw;
          if (dw != '0 && cur_cmd == CMD_MWI) nxt_cmd = CMD_MW;
        end
      end
      default: aborted = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwr_err_report.sv
module pwr_err_report (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_ev,
  input  logic nodeliv_ev,
  input  logic serr_en,
  input  logic nodeliv_dis,
  output logic serr_req,
  output logic rx_tabort,
  output logic sig_serr
);
  logic fire;
  assign fire = serr_en && (abort_ev || (nodeliv_ev && !nodeliv_dis));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_req  <= 1'b0;
      rx_tabort <= 1'b0;
      sig_serr  <= 1'b0;
    end else begin
      serr_req <= fire;
      if (abort_ev) rx_tabort <= 1'b1;
      if (fire)     sig_serr  <= 1'b1;
    end
  end

  // R8: a system-error request needs the enable
  p_serr_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> $past(serr_en));
  // R8: a request is always mirrored in the sticky status
  p_sig_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> sig_serr);
  // R9: a non-delivery request is blocked by the disable bit
  p_nodeliv_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_req && !$past(abort_ev)) |-> !$past(nodeliv_dis));
endmodule

// File: rtl/pwr_redeliver_ctrl.sv
module pwr_redeliver_ctrl
  import pwr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LW      = 8,
  parameter int MAX_ATT = 1 << 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_serr_en,
  input  logic          cfg_nodeliv_dis,
  input  logic          ent_valid,
  output logic          ent_ready,
  input  logic [AW-1:0] ent_addr,
  input  logic [3:0]    ent_cmd,
  input  logic [3:0]    ent_be,
  input  logic [LW-1:0] ent_len,
  output logic          att_valid,
  input  logic          att_ready,
  output logic [AW-1:0] att_addr,
  output logic [3:0]    att_cmd,
  output logic [3:0]    att_be,
  output logic [LW-1:0] att_len,
  input  logic          term_valid,
  input  logic [1:0]    term_code,
  input  logic [LW-1:0] term_dw,
  output logic          done_pulse,
  output logic          done_flushed,
  output logic          serr_req,
  output logic          sts_rx_tabort,
  output logic          sts_sig_serr
);
  pwr_state_e    state;
  logic [AW-1:0] cur_addr, nxt_addr;
  logic [3:0]    cur_cmd, nxt_cmd, cur_be;
  logic [LW-1:0] cur_rem, nxt_rem;
  logic          finished, aborted, leftover, at_limit;
  logic          ent_fire, att_fire, take, fail;

  assign ent_ready = (state == ST_IDLE);
  assign att_valid = (state == ST_ISSUE);
  assign ent_fire  = ent_valid && ent_ready;
  assign att_fire  = att_valid && att_ready;
  assign take      = (state == ST_WAIT) && term_valid;
  assign fail      = take && leftover && at_limit;

  assign att_addr = cur_addr;
  assign att_cmd  = cur_cmd;
  assign att_be   = cur_be;
  assign att_len  = cur_rem;

  pwr_next_calc #(.AW(AW), .LW(LW)) u_calc (
    .cur_addr(cur_addr), .cur_cmd(cur_cmd), .cur_rem(cur_rem),
    .code(term_code), .dw(term_dw),
    .nxt_addr(nxt_addr), .nxt_cmd(nxt_cmd), .nxt_rem(nxt_rem),
    .finished(finished), .aborted(aborted), .leftover(leftover)
  );

  pwr_attempt_ctr #(.MAX_ATT(MAX_ATT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(ent_fire), .inc(att_fire),
    .at_limit(at_limit)
  );

  pwr_err_report u_err (
    .clk(clk), .rst_n(rst_n),
    .abort_ev(take && aborted), .nodeliv_ev(fail),
    .serr_en(cfg_serr_en), .nodeliv_dis(cfg_nodeliv_dis),
    .serr_req(serr_req), .rx_tabort(sts_rx_tabort), .sig_serr(sts_sig_serr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cur_addr     <= '0;
      cur_cmd      <= '0;
      cur_be       <= '0;
      cur_rem      <= '0;
      done_pulse   <= 1'b0;
      done_flushed <= 1'b0;
    end else begin
      done_pulse   <= 1'b0;
      done_flushed <= 1'b0;
      case (state)
        ST_IDLE: if (ent_fire) begin
          cur_addr <= ent_addr;
          cur_cmd  <= ent_cmd;
          cur_be   <= ent_be;
          cur_rem  <= ent_len;
          state    <= ST_ISSUE;
        end
        ST_ISSUE: if (att_fire) state <= ST_WAIT;
        ST_WAIT: if (take) begin
          if (finished || aborted || fail) begin
            state        <= ST_IDLE;
            done_pulse   <= 1'b1;
            done_flushed <= aborted || fail;
          end else begin
            cur_addr <= nxt_addr;
            cur_cmd  <= nxt_cmd;
            cur_rem  <= nxt_rem;
            state    <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: no second request before the termination of the first
  p_single_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    att_fire |=> !att_valid);
  // R4: a retry re-drives the same address and count
  p_retry_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && term_code == TERM_RETRY && !at_limit)
      |=> (att_valid && $stable(att_addr) && $stable(att_len)));
  // R6: partial delivery leaves no invalidate command behind
  p_mwi_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && term_code == TERM_DISC && term_dw != '0 && term_dw < cur_rem && !at_limit)
      |=> att_cmd != CMD_MWI);
  // R3: a retired entry leaves the controller idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ent_ready);
  // R8: an abort always flushes
  p_abort_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && term_code == TERM_ABORT) |=> (done_pulse && done_flushed));
endmodule

// File: tb/pwr_redeliver_ctrl_bench.sv
module pwr_redeliver_ctrl_bench;
  localparam int AW = 16;
  localparam int LW = 4;
  localparam int MAX_ATT = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_serr_en = 1'b0, cfg_nodeliv_dis = 1'b0;
  logic ent_valid = 1'b0, ent_ready;
  logic [AW-1:0] ent_addr = '0;
  logic [3:0] ent_cmd = '0, ent_be = '0;
  logic [LW-1:0] ent_len = '0;
  logic att_valid, att_ready = 1'b0;
  logic [AW-1:0] att_addr;
  logic [3:0] att_cmd, att_be;
  logic [LW-1:0] att_len;
  logic term_valid = 1'b0;
  logic [1:0] term_code = '0;
  logic [LW-1:0] term_dw = '0;
  logic done_pulse, done_flushed, serr_req, sts_rx_tabort, sts_sig_serr;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_redeliver_ctrl #(.AW(AW), .LW(LW), .MAX_ATT(MAX_ATT)) u_pwr_redeliver_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_serr_en(cfg_serr_en), .cfg_nodeliv_dis(cfg_nodeliv_dis),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr), .ent_cmd(ent_cmd),
    .ent_be(ent_be), .ent_len(ent_len), .att_valid(att_valid), .att_ready(att_ready),
    .att_addr(att_addr), .att_cmd(att_cmd), .att_be(att_be), .att_len(att_len),
    .term_valid(term_valid), .term_code(term_code), .term_dw(term_dw),
    .done_pulse(done_pulse), .done_flushed(done_flushed), .serr_req(serr_req),
    .sts_rx_tabort(sts_rx_tabort), .sts_sig_serr(sts_sig_serr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_entry(input logic [AW-1:0] a, input logic [3:0] c,
                            input logic [3:0] b, input int n);
    @(negedge clk);
    ent_addr = a; ent_cmd = c; ent_be = b; ent_len = LW'(n); ent_valid = 1'b1;
    while (!ent_ready) @(negedge clk);
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic take_attempt(output logic [AW-1:0] a, output logic [3:0] c,
                              output logic [3:0] b, output int n);
    att_ready = 1'b1;
    while (!att_valid) @(negedge clk);
    a = att_addr; c = att_cmd; b = att_be; n = int'(att_len);
    @(negedge clk);
    att_ready = 1'b0;
  endtask

  task automatic terminate(input logic [1:0] code, input int dw,
                           output bit d, output bit f, output bit s);
    term_valid = 1'b1; term_code = code; term_dw = LW'(dw);
    @(negedge clk);
    term_valid = 1'b0;
    d = done_pulse; f = done_flushed; s = serr_req;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a; logic [3:0] c, b; int n;
    bit d, f, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ent_ready && !att_valid && !done_pulse && !serr_req && !sts_rx_tabort && !sts_sig_serr,
          "R1 reset state", {ent_ready, att_valid, done_pulse, serr_req}, 4'b1000);
    // term strobe with nothing outstanding is ignored
    term_valid = 1'b1; term_code = 2'd3; @(negedge clk); term_valid = 1'b0;
    @(negedge clk);
    check(!done_pulse && !sts_rx_tabort && ent_ready, "R2 stray termination ignored",
          {done_pulse, sts_rx_tabort}, 0);

    // disconnect sweep: R1 R5 R6 R7 R3 R2
    for (int ci = 0; ci < 2; ci++) begin
      for (int len = 1; len <= 7; len++) begin
        for (int dw = 0; dw <= len; dw++) begin
          logic [3:0] cmd; logic [AW-1:0] base; logic [3:0] be;
          cmd  = (ci == 0) ? 4'h7 : 4'hF;
          base = AW'(32'h1000 + len * 256 + dw * 16);
          be   = 4'(len + dw);
          send_entry(base, cmd, be, len);
          take_attempt(a, c, b, n);
          check(a == base && c == cmd && b == be && n == len, "R1 first attempt",
                int'(a), int'(base));
          check(!att_valid, "R2 one outstanding", att_valid, 0);
          terminate(2'd2, dw, d, f, s);
          if (dw >= len) begin
            check(d && !f, "R7 full disconnect retires", {d, f}, 2'b10);
          end else begin
            logic [3:0] ec;
            check(!d, "R5 partial disconnect continues", d, 0);
            ec = (cmd == 4'hF && dw > 0) ? 4'h7 : cmd;
            take_attempt(a, c, b, n);
            check(a == AW'(base + 4 * dw) && n == len - dw && b == be, "R5 resume address",
                  int'(a), int'(base + 4 * dw));
            check(c == ec, "R6 command after disconnect", c, ec);
            terminate(2'd0, 0, d, f, s);
            check(d && !f && ent_ready, "R3 normal retires", {d, f}, 2'b10);
          end
        end
      end
    end

    // aborts: R8
    cfg_serr_en = 1'b0;
    send_entry(16'h4000, 4'h7, 4'hF, 3);
    take_attempt(a, c, b, n);
    terminate(2'd3, 0, d, f, s);
    check(d && f && !s, "R8 abort flush no serr", {d, f, s}, 3'b110);
    check(sts_rx_tabort && !sts_sig_serr, "R8 abort status", {sts_rx_tabort, sts_sig_serr}, 2'b10);
    cfg_serr_en = 1'b1;
    send_entry(16'h4100, 4'hF, 4'h3, 2);
    take_attempt(a, c, b, n);
    terminate(2'd1, 0, d, f, s);
    take_attempt(a, c, b, n);
    terminate(2'd3, 0, d, f, s);
    check(d && f && s, "R8 abort flush with serr", {d, f, s}, 3'b111);
    check(sts_rx_tabort && sts_sig_serr, "R8 serr status", {sts_rx_tabort, sts_sig_serr}, 2'b11);

    // attempt limit sweep: R4 R9 R10
    for (int k = 0; k < 4; k++) begin
      for (int rep = 0; rep < 2; rep++) begin
        logic [AW-1:0] base; bit es;
        cfg_serr_en = k[0]; cfg_nodeliv_dis = k[1];
        es = k[0] && !k[1];
        base = AW'(32'h8000 + k * 64 + rep * 8);
        send_entry(base, 4'hF, 4'h5, 5);
        for (int i = 1; i <= MAX_ATT; i++) begin
          take_attempt(a, c, b, n);
          check(a == base && c == 4'hF && n == 5 && b == 4'h5, "R4 retry same attempt",
                int'(a), int'(base));
          if (i == MAX_ATT) begin
            terminate(2'd2, 2, d, f, s);
            check(d && f, "R9 limit flush", {d, f}, 2'b11);
            check(s == es, "R9 serr gating", s, es);
          end else begin
            terminate(2'd1, 0, d, f, s);
            check(!d && !s, "R10 budget restarted per entry", {d, s}, 0);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule